// File: doc/BRIEF.md
# High-Speed ADC Frame Sample Unpacker

This block belongs to the transport stage of a multi-lane serial ADC receiver. Its input is a wide word from the link layer whose lanes are already aligned. The word is cut into 32-bit lane slices, sixteen of them by default, so the word is 512 bits wide. Two consecutive words form one frame. Each lane slice carries five 12-bit samples across its two words, plus 4 padding bits. The samples are interleaved across the lanes, and one sample in every lane is split across the boundary between the two words.

The block rebuilds the frame in sample order and releases it as two half-frames on consecutive link clocks. The first half comes out first, then the second. A frame-start marker on the input marks the first word of each frame. A stall on the input valid freezes frame tracking. A marker that arrives in the middle of a frame drops the partial frame and starts again from the marked word.

Top module: `adc_frame_unpack`

## Requirements
- R1: During and directly after reset, `out_valid` is 0, `out_samples` is all zeros, and the block waits for the first word of a frame.
- R2: Within one lane slice (bit 31 is the slice MSB):
  - The first word holds sample A in bits 31:20 and sample B in bits 19:8. Bits 7:0 are the upper 8 bits of sample C.
  - The second word holds the lower 4 bits of sample C in bits 31:28, sample D in bits 27:16 and sample E in bits 15:4.
  - Every sample is rebuilt bit-exact.
- R3: Lane slice k occupies word bits 32k+31 down to 32k. For k below LANES/2 its samples A..E are frame samples 2k + LANES*j, with j = 0..4. For the other lanes they are 2(k-LANES/2)+1 + LANES*j.
- R4: The first output cycle of a frame carries samples 0..39 and the next cycle carries samples 40..79. Within the 480-bit bus the lowest-numbered sample sits in bits 479:468. Each later sample sits in the next lower 12 bits.
- R5: The first half-frame appears on the outputs 2 clocks after the cycle in which the second word is presented. With no stall this is 3 clocks after the first word. The second half-frame follows on the very next clock.
- R6: `out_valid` is 1 exactly for the two cycles that carry a complete half-frame, and 0 otherwise.
- R7: A cycle with `in_valid` = 0 is ignored whatever `in_sof` and `in_data` hold. A frame stalled between its two words is still recovered intact.
- R8: Bits 3:0 of each lane slice in the second word have no effect on the output.
- R9: A valid word with `in_sof` = 1 that arrives while the second word is expected drops the partial frame. The new word becomes the first word of a new frame, and only that new frame is output.
- R10: A valid word with `in_sof` = 0 that arrives while a first word is expected is discarded and produces no output.
- R11: Back-to-back frames, one word per clock, give a continuous run of valid half-frames in frame order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_sof | input | 1 | Input word is the first word of a frame |
| in_data | input | 512 | Lane-aligned link word, LANES x 32 bits |
| out_valid | output | 1 | `out_samples` carries a complete half-frame |
| out_samples | output | 480 | Half-frame of 40 samples, lowest sample in the MSBs |

## Verification
The bench builds the block with its default of 16 lanes. That gives a 512-bit word and an 80-sample frame, which is the geometry in which every lane carries one straddling sample. The bench packs random frames with random padding through an independent behavioural packer and checks the output bus against an expected table on every clock. The test sequence covers:
- back-to-back frames;
- stalls between the two words, with garbage driven on the idle cycles;
- mid-frame markers;
- unmarked words that arrive while a first word is expected.

// File: rtl/adc_unpack_pkg.sv
package adc_unpack_pkg;

    // Fixed geometry of one lane slice
    localparam int SAMP_W  = 12;
    localparam int LANE_W  = 32;
    localparam int SLOTS   = 5;
    localparam int SPLIT_HI = LANE_W - 2 * SAMP_W;   // bits of the straddling sample in word 0
    localparam int SPLIT_LO = SAMP_W - SPLIT_HI;     // bits of the straddling sample in word 1
    localparam int PAD_W   = 2 * LANE_W - SLOTS * SAMP_W;
    localparam int USED1_W = LANE_W - PAD_W;         // meaningful bits of word 1 per lane

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic vld;
        logic sof;
    } ctl_t;

    // Frame position of slot j in lane k
    function automatic int samp_index(input int lane, input int slot, input int lanes);
        int half;
        half = lanes / 2;
        return 2 * (lane % half) + (lane / half) + lanes * slot;
    endfunction

endpackage

// File: rtl/adc_unpack_inreg.sv
module adc_unpack_inreg
    import adc_unpack_pkg::*;
#(
    parameter int WORD_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_data,
    output ctl_t              q_ctl,
    output logic [WORD_W-1:0] q_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_ctl  <= '0;
            q_data <= '0;
        end else begin
            q_ctl.vld <= in_valid;
            q_ctl.sof <= in_sof;
            q_data    <= in_data;
        end
    end

endmodule

// File: rtl/adc_unpack_phase.sv
module adc_unpack_phase
    import adc_unpack_pkg::*;
#(
    parameter int WORD_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              q_ctl,
    input  logic [WORD_W-1:0] q_data,
    output phase_e            phase,
    output logic [WORD_W-1:0] hold_q,
    output logic              frame_go
);

    // A frame completes when an unmarked valid word meets a held first word
    assign frame_go = q_ctl.vld && !q_ctl.sof && (phase == PH_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_FIRST;
            hold_q <= '0;
        end else if (q_ctl.vld) begin
            if (q_ctl.sof) begin
                hold_q <= q_data;      // new frame start; any partial frame is dropped
                phase  <= PH_SECOND;
            end else if (phase == PH_SECOND) begin
                phase  <= PH_FIRST;
            end
        end
    end

endmodule

// File: rtl/adc_unpack_lane.sv
module adc_unpack_lane
    import adc_unpack_pkg::*;
(
    input  logic [LANE_W-1:0]        first_slice,
    input  logic [USED1_W-1:0]       second_used,
    output logic [SLOTS*SAMP_W-1:0]  samples
);

    localparam int S1_TOP = USED1_W - 1;

    // slot j sits at samples[(SLOTS-1-j)*SAMP_W +: SAMP_W]
    assign samples[(SLOTS-1)*SAMP_W +: SAMP_W] = first_slice[LANE_W-1 -: SAMP_W];
    assign samples[(SLOTS-2)*SAMP_W +: SAMP_W] = first_slice[LANE_W-1-SAMP_W -: SAMP_W];
    assign samples[(SLOTS-3)*SAMP_W +: SAMP_W] = {first_slice[SPLIT_HI-1:0],
                                                  second_used[S1_TOP -: SPLIT_LO]};
    assign samples[(SLOTS-4)*SAMP_W +: SAMP_W] = second_used[S1_TOP-SPLIT_LO -: SAMP_W];
    assign samples[(SLOTS-5)*SAMP_W +: SAMP_W] = second_used[S1_TOP-SPLIT_LO-SAMP_W -: SAMP_W];

endmodule

// File: rtl/adc_unpack_outsel.sv
module adc_unpack_outsel #(
    parameter int OUT_W = 480
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_go,
    input  logic [2*OUT_W-1:0] frame_bus,
    output logic               out_valid,
    output logic               out_half,
    output logic [OUT_W-1:0]   out_samples
);

    logic [OUT_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_half    <= 1'b0;
            out_samples <= '0;
            pend_q      <= '0;
        end else if (frame_go) begin
            out_samples <= frame_bus[2*OUT_W-1 -: OUT_W];
            pend_q      <= frame_bus[OUT_W-1:0];
            out_valid   <= 1'b1;
            out_half    <= 1'b0;
        end else if (out_valid && !out_half) begin
            out_samples <= pend_q;
            out_valid   <= 1'b1;
            out_half    <= 1'b1;
        end else begin
            out_valid   <= 1'b0;
            out_half    <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_frame_unpack.sv
module adc_frame_unpack
    import adc_unpack_pkg::*;
#(
    parameter int LANES = 16,
    localparam int WORD_W      = LANES * LANE_W,
    localparam int FRAME_SAMPS = LANES * SLOTS,
    localparam int FRAME_W     = FRAME_SAMPS * SAMP_W,
    localparam int OUT_W       = FRAME_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_samples
);

    ctl_t              q_ctl;
    logic [WORD_W-1:0] q_data;
    logic [WORD_W-1:0] hold_q;
    phase_e            phase;
    logic              frame_go;
    logic              out_half;
    logic [FRAME_W-1:0] frame_bus;
    logic [SLOTS*SAMP_W-1:0] lane_smp [LANES];

    adc_unpack_inreg #(.WORD_W(WORD_W)) u_inreg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .q_ctl(q_ctl), .q_data(q_data)
    );

    adc_unpack_phase #(.WORD_W(WORD_W)) u_phase (
        .clk(clk), .rst(rst), .q_ctl(q_ctl), .q_data(q_data),
        .phase(phase), .hold_q(hold_q), .frame_go(frame_go)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        adc_unpack_lane u_lane (
            .first_slice(hold_q[k*LANE_W +: LANE_W]),
            .second_used(q_data[k*LANE_W+PAD_W +: USED1_W]),
            .samples(lane_smp[k])
        );
        for (genvar j = 0; j < SLOTS; j++) begin : g_slot
            localparam int IDX = samp_index(k, j, LANES);
            assign frame_bus[FRAME_W-1-IDX*SAMP_W -: SAMP_W] =
                lane_smp[k][(SLOTS-1-j)*SAMP_W +: SAMP_W];
        end
    end

    adc_unpack_outsel #(.OUT_W(OUT_W)) u_outsel (
        .clk(clk), .rst(rst), .frame_go(frame_go), .frame_bus(frame_bus),
        .out_valid(out_valid), .out_half(out_half), .out_samples(out_samples)
    );

endmodule

// File: rtl/adc_frame_unpack_chk.sv
module adc_frame_unpack_chk
    import adc_unpack_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   in_valid,
    input logic   in_sof,
    input logic   q_vld,
    input logic   q_sof,
    input phase_e phase,
    input logic   out_valid,
    input logic   out_half
);

    // R5: a completing second word yields the first half on the next clock
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (q_vld && !q_sof && phase == PH_SECOND) |=> (out_valid && !out_half));

    // R6: first half is always followed by the second half
    p_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_half) |=> (out_valid && out_half));

    // R6: never two second halves in a row
    p_half_once_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_half) |=> !(out_valid && out_half));

    // R7: an idle input cycle leaves frame tracking untouched
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 $stable(phase));

    // R9: a marked valid word always arms the second-word phase
    p_resync_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |=> ##1 (phase == PH_SECOND));

    // R10: an unmarked word while waiting for a first word produces nothing
    p_discard_r10: assert property (@(posedge clk) disable iff (rst)
        (q_vld && !q_sof && phase == PH_FIRST && !(out_valid && !out_half)) |=> !out_valid);

endmodule

bind adc_frame_unpack adc_frame_unpack_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .q_vld(q_ctl.vld), .q_sof(q_ctl.sof), .phase(phase),
    .out_valid(out_valid), .out_half(out_half)
);

// File: tb/adc_frame_unpack_tb.sv
module adc_frame_unpack_tb;

    localparam int SW = 12;
    localparam int FS = 80;
    localparam int HS = 40;
    localparam int WW = 512;
    localparam int OW = 480;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic [WW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_samples;

    adc_frame_unpack u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_samples(out_samples)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  pad_rand = 0;
    bit  exp_second = 0;
    string cur_req = "R6";

    logic [SW-1:0] frm  [FS];
    logic [SW-1:0] pend [FS];
    logic [WW-1:0] pw0, pw1;
    logic [OW-1:0] exp_dat [int];
    string         exp_tag [int];

    task automatic check(input bit ok, input string req, input logic [OW-1:0] act,
                         input logic [OW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Behavioural packer following the lane layout in the requirements
    task automatic pack();
        for (int k = 0; k < 16; k++) begin
            int b;
            logic [SW-1:0] a, bb, c, d, e;
            logic [3:0] pad;
            b  = (k < 8) ? 2 * k : 2 * (k - 8) + 1;
            a  = frm[b];
            bb = frm[b + 16];
            c  = frm[b + 32];
            d  = frm[b + 48];
            e  = frm[b + 64];
            pad = pad_rand ? 4'($urandom) : 4'h0;
            pw0[32*k +: 32] = {a, bb, c[11:4]};
            pw1[32*k +: 32] = {c[3:0], d, e, pad};
        end
    endtask

    function automatic logic [OW-1:0] half_vec(input int h);
        logic [OW-1:0] v;
        for (int i = 0; i < HS; i++) v[OW-1-SW*i -: SW] = pend[h*HS + i];
        return v;
    endfunction

    task automatic rand_frame();
        for (int i = 0; i < FS; i++) frm[i] = SW'($urandom);
    endtask

    // Drive one input cycle and update the behavioural model
    task automatic drive(input bit v, input bit s, input logic [WW-1:0] w);
        @(negedge clk);
        in_valid = v;
        in_sof   = s;
        in_data  = w;
        if (v && s) begin
            pend = frm;
            exp_second = 1;
        end else if (v && exp_second) begin
            exp_dat[cyc + 2] = half_vec(0);
            exp_tag[cyc + 2] = {cur_req, " R4 R5 first half"};
            exp_dat[cyc + 3] = half_vec(1);
            exp_tag[cyc + 3] = {cur_req, " R4 R5 second half"};
            exp_second = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'($urandom), {16{32'($urandom)}});
    endtask

    task automatic send_frame(input int gap);
        pack();
        drive(1'b1, 1'b1, pw0);
        if (gap > 0) idle(gap);
        drive(1'b1, 1'b0, pw1);
    endtask

    // Cycle-by-cycle comparison against the expected table
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_dat.exists(cyc)) begin
                check(out_valid === 1'b1, {exp_tag[cyc], " R6 valid"}, OW'(out_valid), OW'(1));
                check(out_samples === exp_dat[cyc], {exp_tag[cyc], " R2 R3 data"},
                      out_samples, exp_dat[cyc]);
            end else begin
                check(out_valid === 1'b0, {cur_req, " R6 idle"}, OW'(out_valid), OW'(0));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 reset valid", OW'(out_valid), OW'(0));
        check(out_samples === '0, "R1 reset data", out_samples, '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 after reset", OW'(out_valid), OW'(0));

        // R2/R3: deterministic distinctive frame, zero padding
        cur_req = "R2 R3";
        for (int i = 0; i < FS; i++) frm[i] = SW'(i * 263 + 17);
        send_frame(0);
        idle(4);

        // R8: same frame with random padding must give identical output
        cur_req = "R8";
        pad_rand = 1;
        send_frame(0);
        idle(4);

        // R11: back-to-back random frames
        cur_req = "R11";
        for (int f = 0; f < 20; f++) begin
            rand_frame();
            send_frame(0);
        end
        idle(4);

        // R7: stalls between words with garbage, including marker while idle
        cur_req = "R7";
        for (int f = 0; f < 10; f++) begin
            rand_frame();
            send_frame(1 + (f % 4));
            idle(f % 3);
        end
        idle(4);

        // R9: marker while expecting the second word drops the partial frame
        cur_req = "R9";
        for (int f = 0; f < 5; f++) begin
            rand_frame();
            pack();
            drive(1'b1, 1'b1, pw0);
            rand_frame();
            send_frame(f % 2);
            idle(2);
        end
        idle(4);

        // R10: unmarked words while waiting for a first word are discarded
        cur_req = "R10";
        for (int f = 0; f < 4; f++) begin
            drive(1'b1, 1'b0, {16{32'($urandom)}});
            drive(1'b1, 1'b0, {16{32'($urandom)}});
            rand_frame();
            send_frame(0);
            drive(1'b1, 1'b0, {16{32'($urandom)}});
        end
        idle(8);

        done = 1;
        summary();
        $finish;
    end

endmodule